// File: doc/BRIEF.md
# External Bus Mastership Handshake Controller

This block is the master side of a shared external bus. A separate arbiter decides which master owns the bus. The block asks the arbiter for the bus when the local side has external work to do. It waits for a grant, and once the bus is idle it takes ownership by pulling the bus-busy line low. It gives the bus up again only at the boundary of an external bus cycle.

The three external handshake signals are active low:
- a request output that is always driven;
- a grant input;
- a bidirectional busy line, modelled as a drive enable, a drive value and a sampled input.

Grant and the sampled busy value pass through a synchronizer before any decision is made.

While grant stays asserted, the block can park on the bus. It keeps busy low with no work pending, and it can resume at once without arbitrating again. To let go of the line, it drives busy high for exactly one clock and then stops driving, so an external pull-up holds the line high. Software controls two bits. A hold bit keeps the request asserted with no access pending. An enable bit must be set for grant and busy to be honoured at all.

Top module: `ext_bus_master_ctl`

## Requirements
- R1: `req_n` is driven on every cycle and is a register of the request: it goes low on the clock after `acc_req` or `hold_req` is high, and high on the clock after both are low. This holds whether the block is master or not.
- R2: With `acc_req` low, setting `hold_req` alone pulls `req_n` low on the next clock.
- R3: While `rst_n` is low, `req_n` is 1, `owned` is 0 and `busy_oe` is 0 (slave state), whatever the other inputs are.
- R4: With the bus idle (`busy_in` high) and `acc_req` held high, `owned` rises on the fourth rising clock after `grant_n` falls, and not before. This is two synchronizer clocks, one clock to start waiting for busy, and one clock to take the bus.
- R5: While the busy line is held low by another device, a granted block stays out of ownership with `busy_oe` at 0. It takes ownership on the third clock after the line goes high.
- R6: While `owned` is 1, the block drives the busy line low (`busy_oe` = 1, `busy_out` = 0).
- R7: When grant is removed during an access, ownership is kept until `cyc_done` marks the end of the current bus cycle, however long that takes.
- R8: With grant held, dropping `acc_req` keeps `owned` at 1 and busy driven low (parking), while `req_n` returns high.
- R9: A new access from the parked state continues ownership with no release and no re-arbitration: `owned` stays 1 and no release drive occurs.
- R10: Giving up ownership drives the busy line high (`busy_oe` = 1, `busy_out` = 1) for exactly one clock directly after `owned` falls. The next clock sets `busy_oe` to 0.
- R11: With `arb_en` at 0, grant is ignored and ownership is never taken. Clearing `arb_en` while parked releases the bus on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Local side wants external bus cycles; held until its last cycle ends |
| cyc_done | input | 1 | One-clock strobe at the end of each external bus cycle |
| hold_req | input | 1 | Software bit forcing the request asserted |
| arb_en | input | 1 | Software bit enabling grant and busy handling |
| grant_n | input | 1 | Active-low grant from the arbiter, asynchronous |
| busy_in | input | 1 | Sampled level of the shared busy line, asynchronous |
| req_n | output | 1 | Active-low bus request, always driven |
| busy_oe | output | 1 | Drive enable for the busy line |
| busy_out | output | 1 | Value driven on the busy line when enabled |
| owned | output | 1 | Block is current bus master |

## Verification
The request assertions assume `acc_req` and `hold_req` are synchronous to `clk`. The stimulus changes them only on falling edges. The ownership checks assume `acc_req` drops only between bus cycles, and that `cyc_done` is a single-clock pulse given only while an access is in progress. The directed scenarios follow both rules. The bench models the busy line as the block's own drive when enabled, and otherwise as the level set by a stand-in for another master with a pull-up. It never lets both drive at once, so the sampled busy value always reflects a legal bus.

// File: rtl/ext_bus_master_ctl.sv
module ext_bus_master_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic cyc_done,
  input  logic hold_req,
  input  logic arb_en,
  input  logic grant_n,
  input  logic busy_in,
  output logic req_n,
  output logic busy_oe,
  output logic busy_out,
  output logic owned
);

  localparam int SMSB = SYNC_STAGES - 1;

  typedef enum logic [2:0] {
    S_SLAVE,
    S_WAIT_BUSY,
    S_ACTIVE,
    S_PARKED,
    S_RELEASE_HI
  } state_t;

  state_t state, state_nx;
  logic [SMSB:0] gnt_sync, bsy_sync;
  logic gnt_ok, bus_free, need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_sync <= '0;
      bsy_sync <= '0;
    end else begin
      gnt_sync <= {gnt_sync[SMSB-1:0], ~grant_n};
      bsy_sync <= {bsy_sync[SMSB-1:0], ~busy_in};
    end
  end

  assign gnt_ok   = arb_en & gnt_sync[SMSB];
  assign bus_free = ~bsy_sync[SMSB];
  assign need     = acc_req | hold_req;

  always_comb begin
    state_nx = state;
    case (state)
      S_SLAVE:
        if (gnt_ok && need) state_nx = S_WAIT_BUSY;
      S_WAIT_BUSY:
        if (!gnt_ok) state_nx = S_SLAVE;
        else if (bus_free) state_nx = acc_req ? S_ACTIVE : S_PARKED;
      S_ACTIVE:
        if (!gnt_ok && (cyc_done || !acc_req)) state_nx = S_RELEASE_HI;
        else if (!acc_req) state_nx = S_PARKED;
      S_PARKED:
        if (!gnt_ok) state_nx = S_RELEASE_HI;
        else if (acc_req) state_nx = S_ACTIVE;
      S_RELEASE_HI:
        state_nx = S_SLAVE;
      default:
        state_nx = S_SLAVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_SLAVE;
      req_n <= 1'b1;
    end else begin
      state <= state_nx;
      req_n <= ~need;
    end
  end

  assign owned    = (state == S_ACTIVE) || (state == S_PARKED);
  assign busy_oe  = owned || (state == S_RELEASE_HI);
  assign busy_out = (state == S_RELEASE_HI);

endmodule

// File: rtl/ext_bus_master_ctl_chk.sv
module ext_bus_master_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_req,
  input logic hold_req,
  input logic req_n,
  input logic busy_oe,
  input logic busy_out,
  input logic owned
);

  // R1
  req_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req || hold_req) |=> !req_n);

  // R1
  req_deassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req || hold_req) |=> req_n);

  // R6
  owned_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owned |-> (busy_oe && !busy_out));

  // R10
  release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe && busy_out) |=> !busy_oe);

  // R10
  owned_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(owned) |-> (busy_oe && busy_out));

endmodule

bind ext_bus_master_ctl ext_bus_master_ctl_chk u_chk (.*);

// File: tb/ext_bus_master_ctl_test.sv
module ext_bus_master_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_req = 1'b0, cyc_done = 1'b0, hold_req = 1'b0, arb_en = 1'b1;
  logic grant_n = 1'b1, ext_busy_n = 1'b1;
  logic busy_in, req_n, busy_oe, busy_out, owned;
  int checks = 0, fails = 0, cycles = 0, rel_cnt = 0;
  bit done = 1'b0;

  assign busy_in = busy_oe ? busy_out : ext_busy_n;

  ext_bus_master_ctl uut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .cyc_done(cyc_done),
    .hold_req(hold_req), .arb_en(arb_en), .grant_n(grant_n), .busy_in(busy_in),
    .req_n(req_n), .busy_oe(busy_oe), .busy_out(busy_out), .owned(owned)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (busy_oe && busy_out) rel_cnt++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic t_reset();
    acc_req = 1'b1;
    step(2);
    chk("R3", "req_n in reset", req_n, 1);
    chk("R3", "owned in reset", owned, 0);
    chk("R3", "busy_oe in reset", busy_oe, 0);
    acc_req = 1'b0;
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_request();
    acc_req = 1'b1;
    chk("R1", "req_n before edge", req_n, 1);
    step(1);
    chk("R1", "req_n asserted", req_n, 0);
    acc_req = 1'b0;
    step(1);
    chk("R1", "req_n deasserted", req_n, 1);
    hold_req = 1'b1;
    step(1);
    chk("R2", "req_n from hold bit", req_n, 0);
    chk("R2", "no ownership without grant", owned, 0);
    hold_req = 1'b0;
    step(1);
    chk("R2", "req_n after hold cleared", req_n, 1);
  endtask

  task automatic t_acquire();
    grant_n = 1'b0;
    acc_req = 1'b1;
    step(3);
    chk("R4", "owned after 3 clocks", owned, 0);
    step(1);
    chk("R4", "owned after 4 clocks", owned, 1);
    chk("R6", "busy_oe while owned", busy_oe, 1);
    chk("R6", "busy_out while owned", busy_out, 0);
  endtask

  task automatic t_park();
    int base = rel_cnt;
    acc_req = 1'b0;
    step(1);
    chk("R8", "req_n after drop", req_n, 1);
    chk("R8", "owned while parked", owned, 1);
    chk("R8", "busy driven low parked", busy_oe && !busy_out, 1);
    step(5);
    chk("R8", "still parked", owned, 1);
    acc_req = 1'b1;
    step(1);
    chk("R9", "owned on new access", owned, 1);
    step(2);
    chk("R9", "no release cycle", rel_cnt - base, 0);
  endtask

  task automatic t_grant_drop();
    grant_n = 1'b1;
    step(6);
    chk("R7", "owned until cycle end", owned, 1);
    cyc_done = 1'b1;
    step(1);
    cyc_done = 1'b0;
    chk("R7", "owned after cycle end", owned, 0);
    chk("R10", "release busy_oe", busy_oe, 1);
    chk("R10", "release busy_out", busy_out, 1);
    step(1);
    chk("R10", "line released", busy_oe, 0);
    chk("R1", "req_n still low as slave", req_n, 0);
  endtask

  task automatic t_busy_wait();
    ext_busy_n = 1'b0;
    step(3);
    grant_n = 1'b0;
    step(8);
    chk("R5", "no ownership while busy", owned, 0);
    chk("R5", "no drive while busy", busy_oe, 0);
    ext_busy_n = 1'b1;
    step(2);
    chk("R5", "owned 2 clocks after free", owned, 0);
    step(1);
    chk("R5", "owned 3 clocks after free", owned, 1);
  endtask

  task automatic t_arb_disable();
    rst_n = 1'b0;
    acc_req = 1'b0;
    grant_n = 1'b1;
    step(2);
    rst_n = 1'b1;
    arb_en = 1'b0;
    grant_n = 1'b0;
    acc_req = 1'b1;
    step(8);
    chk("R11", "grant ignored when disabled", owned, 0);
    chk("R11", "no drive when disabled", busy_oe, 0);
    arb_en = 1'b1;
    step(1);
    chk("R11", "not owned one clock after enable", owned, 0);
    step(1);
    chk("R11", "owned two clocks after enable", owned, 1);
    acc_req = 1'b0;
    step(1);
    chk("R8", "parked before disable", owned, 1);
    arb_en = 1'b0;
    step(1);
    chk("R11", "released after disable", owned, 0);
    chk("R10", "drive high after disable", busy_oe && busy_out, 1);
    step(1);
    chk("R10", "tri-state after drive high", busy_oe, 0);
  endtask

  initial begin
    t_reset();
    t_request();
    t_acquire();
    t_park();
    t_grant_drop();
    t_busy_wait();
    t_arb_disable();
    step(2);
    finish_run();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, MAX_CYCLES);
        finish_run();
      end
    end
  end
endmodule